// File: doc/BRIEF.md
# Configuration Write CRC Checker

This block watches the register writes that a configuration packet parser emits and keeps a running 32-bit checksum over them. Every write folds both the 5-bit register address and the 32-bit data word into the checksum, so a corrupted address is caught as surely as a corrupted data word.

The configuration stream checks itself in-band. It carries the expected checksum as an ordinary write to a dedicated check register. The block compares that value with its running checksum. On a mismatch it raises a sticky error bit, which feeds a status register. On a match it restarts the checksum from zero. A stream that does not need checking can write a clear code to the command register instead, which zeroes the running value.

Top module: `cfg_crc_check`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, crc_value is 0 and crc_error is 0.
- R2: On a write to any register other than the check register (address 0), except the clear command, crc_value on the next cycle equals the fold of a 37-bit message into the old value. The message is wr_addr bits 0 to 4 followed by wr_data bits 0 to 31. For each bit b in turn: f = crc[31] xor b; crc = (crc << 1) xor (f ? 0x1EDC6F41 : 0).
- R3: A write to the check register (address 0) whose data differs from the current crc_value sets crc_error on the next cycle.
- R4: A write of data 0x00000007 to the command register (address 4) makes crc_value 0 on the next cycle, and that write is not folded.
- R5: Once set, crc_error stays set, through later matching checks and any other writes, until reset.
- R6: A write to the check register whose data equals crc_value makes crc_value 0 on the next cycle and leaves crc_error unchanged.
- R7: A mismatching write to the check register leaves crc_value unchanged. Writes to the check register are never folded.
- R8: A write to the command register with any data other than 0x00000007 is folded like any other register write (R2).
- R9: In a cycle with wr_en low, crc_value and crc_error hold their values.
- R10: A check write in the cycle right after another write compares against the value that already includes that earlier write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe from the packet parser |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 32 | Data word of the write |
| crc_value | output | 32 | Running checksum |
| crc_error | output | 1 | Sticky checksum-mismatch flag |

## Verification
Two functions meet in one cycle when a check write arrives directly after a folded write: the comparison must use the checksum that the previous cycle has just produced. The bench issues writes on consecutive cycles with no gap. The first is a fold, or the clear command followed by a check of zero. The second is a check whose data the bench computes from the model state that includes that fold. A correct design reports no error and returns to zero. A design that compares against a stale value raises the error flag, and the scoreboard reports it.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
    localparam int CRC_W  = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FOLD  = 2'd1,
        WK_CHECK = 2'd2,
        WK_CLEAR = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             err;
    } crc_state_t;
endpackage

// File: rtl/cfg_crc_decode.sv
module cfg_crc_decode
    import cfg_crc_pkg::*;
#(
    parameter int          AW        = ADDR_W,
    parameter int          DW        = CRC_W,
    parameter logic [4:0]  CHECK_ADR = 5'd0,
    parameter logic [4:0]  CMD_ADR   = 5'd4,
    parameter logic [31:0] CLR_CODE  = 32'd7
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output wr_kind_e      kind
);
    localparam logic [AW-1:0] CHK = AW'(CHECK_ADR);
    localparam logic [AW-1:0] CMD = AW'(CMD_ADR);
    localparam logic [DW-1:0] CLR = DW'(CLR_CODE);

    always_comb begin
        if (!wr_en)                            kind = WK_IDLE;
        else if (wr_addr == CHK)               kind = WK_CHECK;
        else if (wr_addr == CMD && wr_data == CLR) kind = WK_CLEAR;
        else                                   kind = WK_FOLD;
    end
endmodule

// File: rtl/cfg_crc_fold.sv
module cfg_crc_fold #(
    parameter int          AW   = 5,
    parameter int          DW   = 32,
    parameter int          CW   = 32,
    parameter logic [31:0] POLY = 32'h1EDC6F41
) (
    input  logic [CW-1:0] crc_in,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] crc_out
);
    localparam int MSG_W = AW + DW;
    localparam logic [CW-1:0] P = CW'(POLY);

    logic [MSG_W-1:0] msg;
    assign msg = {data, addr};

    // bit 0 of msg (address LSB) enters first
    always_comb begin
        logic [CW-1:0] c;
        logic          fb;
        c = crc_in;
        for (int i = 0; i < MSG_W; i++) begin
            fb = c[CW-1] ^ msg[i];
            c  = {c[CW-2:0], 1'b0} ^ (fb ? P : '0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/cfg_crc_check.sv
module cfg_crc_check
    import cfg_crc_pkg::*;
#(
    parameter int          AW        = ADDR_W,
    parameter int          DW        = CRC_W,
    parameter logic [31:0] POLY      = 32'h1EDC6F41,
    parameter logic [4:0]  CHECK_ADR = 5'd0,
    parameter logic [4:0]  CMD_ADR   = 5'd4,
    parameter logic [31:0] CLR_CODE  = 32'd7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] crc_value,
    output logic          crc_error
);
    wr_kind_e     kind;
    logic [DW-1:0] folded;

    typedef struct packed {
        logic [DW-1:0] crc;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    cfg_crc_decode #(
        .AW(AW), .DW(DW), .CHECK_ADR(CHECK_ADR),
        .CMD_ADR(CMD_ADR), .CLR_CODE(CLR_CODE)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .kind   (kind)
    );

    cfg_crc_fold #(
        .AW(AW), .DW(DW), .CW(DW), .POLY(POLY)
    ) u_fold (
        .crc_in (st_q.crc),
        .addr   (wr_addr),
        .data   (wr_data),
        .crc_out(folded)
    );

    always_comb begin
        st_d = st_q;
        unique case (kind)
            WK_FOLD:  st_d.crc = folded;
            WK_CLEAR: st_d.crc = '0;
            WK_CHECK: begin
                if (wr_data == st_q.crc) st_d.crc = '0;
                else                     st_d.err = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_value = st_q.crc;
    assign crc_error = st_q.err;
endmodule

// File: rtl/cfg_crc_check_sva.sv
module cfg_crc_check_sva #(
    parameter int          AW        = 5,
    parameter int          DW        = 32,
    parameter logic [4:0]  CHECK_ADR = 5'd0,
    parameter logic [4:0]  CMD_ADR   = 5'd4,
    parameter logic [31:0] CLR_CODE  = 32'd7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] crc_value,
    input logic          crc_error
);
    localparam logic [AW-1:0] CHK = AW'(CHECK_ADR);
    localparam logic [AW-1:0] CMD = AW'(CMD_ADR);
    localparam logic [DW-1:0] CLR = DW'(CLR_CODE);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (crc_value == '0 && !crc_error));

    p_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CHK && wr_data != crc_value) |=> crc_error);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CMD && wr_data == CLR) |=> crc_value == '0);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |=> crc_error);

    p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CHK && wr_data == crc_value)
        |=> (crc_value == '0 && crc_error == $past(crc_error)));

    p_nofold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CHK && wr_data != crc_value) |=> $stable(crc_value));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(crc_value) && $stable(crc_error)));
endmodule

bind cfg_crc_check cfg_crc_check_sva #(
    .AW(AW), .DW(DW), .CHECK_ADR(CHECK_ADR),
    .CMD_ADR(CMD_ADR), .CLR_CODE(CLR_CODE)
) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crc_value(crc_value), .crc_error(crc_error)
);

// File: tb/cfg_crc_check_bench.sv
module cfg_crc_check_bench;
    localparam logic [31:0] POLY = 32'h1EDC6F41;
    localparam logic [4:0]  CHK  = 5'd0;
    localparam logic [4:0]  CMD  = 5'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] crc_value;
    logic        crc_error;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_crc = '0;
    logic        m_err = 1'b0;

    logic [31:0] q_crc[$];
    logic        q_err[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    cfg_crc_check u_cfg_crc_check (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .crc_value(crc_value), .crc_error(crc_error)
    );

    function automatic logic [31:0] ref_fold(logic [31:0] c, logic [4:0] a, logic [31:0] d);
        logic [36:0] m;
        logic        f;
        m = {d, a};
        for (int i = 0; i < 37; i++) begin
            f = c[31] ^ m[i];
            c = {c[30:0], 1'b0} ^ (f ? POLY : 32'h0);
        end
        return c;
    endfunction

    task automatic compare(string tag, logic [31:0] ec, logic ee);
        vectors++;
        if (crc_value !== ec || crc_error !== ee) begin
            miscompares++;
            $display("FAIL %s: crc=%h err=%b expected crc=%h err=%b",
                     tag, crc_value, crc_error, ec, ee);
        end
    endtask

    // driver: one cycle per call, expected result queued
    task automatic drive(logic en, logic [4:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        if (en) begin
            if (a == CHK) begin
                if (d == m_crc) m_crc = '0;
                else            m_err = 1'b1;
            end else if (a == CMD && d == 32'd7) begin
                m_crc = '0;
            end else begin
                m_crc = ref_fold(m_crc, a, d);
            end
        end
        q_crc.push_back(m_crc);
        q_err.push_back(m_err);
        q_tag.push_back(tag);
    endtask

    // monitor: result visible after the edge that follows the drive
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_crc.size() > 0)
                compare(q_tag.pop_front(), q_crc.pop_front(), q_err.pop_front());
        end
    end

    task automatic do_reset();
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        m_crc = '0; m_err = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare("R1 during reset", 32'h0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        compare("R1 after release", 32'h0, 1'b0);

        drive(1'b0, 5'd0, 32'h0, "R9 idle at zero");
        drive(1'b1, 5'd2, 32'hDEADBEEF, "R2 fold a");
        drive(1'b1, 5'd31, 32'h0, "R2 fold b");
        drive(1'b1, 5'd1, 32'hFFFFFFFF, "R2 fold c");
        drive(1'b0, 5'd0, 32'h12345678, "R9 idle holds");
        drive(1'b1, CMD, 32'd1, "R8 command other data folds");
        drive(1'b1, CHK, m_crc, "R6 R10 back-to-back match");
        drive(1'b1, 5'd7, 32'hA5A5_0001, "R2 fold after check");
        drive(1'b1, CMD, 32'd7, "R4 clear command");
        drive(1'b1, CHK, 32'h0, "R10 check right after clear");
        drive(1'b1, 5'd9, 32'h0BAD_F00D, "R2 fold d");
        drive(1'b1, CHK, m_crc ^ 32'h1, "R3 R7 mismatch");
        drive(1'b0, 5'd0, 32'h0, "R5 R9 idle after error");
        drive(1'b1, 5'd3, 32'h1357_9BDF, "R5 fold with error set");
        drive(1'b1, CHK, m_crc, "R5 R6 match keeps error");
        drive(1'b1, CMD, 32'd7, "R5 clear keeps error");
        drive(1'b1, 5'd16, 32'h8000_0000, "R2 fold e");
        drive(1'b0, 5'd0, 32'h0, "R9 idle final");

        @(posedge clk); #3;
        do_reset();
        @(negedge clk);
        compare("R1 R5 error cleared by reset", 32'h0, 1'b0);
        drive(1'b1, 5'd12, 32'h0000_0001, "R2 fold after reset");
        drive(1'b1, CHK, m_crc, "R6 match after reset");
        drive(1'b0, 5'd0, 32'h0, "R9 tail");
        @(posedge clk); #3;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule